// File: doc/BRIEF.md
# Fractional Baud Timing Generator

This block derives asynchronous serial bit timing from one system clock. A 16-bit divisor arrives as a high byte and a low byte. It sets the base length of a bit period in clocks. An 8-bit stretch pattern adds one clock to selected bit periods of each character. The average bit period therefore follows a fractional divide ratio, and the timing error does not accumulate over a character.

The block drives three single-cycle strobes. One marks the last clock of every bit period. One marks the middle of the bit, where a receiver samples the line. The third is a clock enable for the oversampling domain of a receive synchronizer. The oversampling enable is divided down by a power of two, chosen from the magnitude of the divisor. This keeps its rate between 16 and 31 times the bit rate. A start pulse, usually raised when a start edge is detected, realigns all timing so that the sample points are measured from the start of the character.

Top module: `baud_frac_gen`

## Requirements
- R1: The divisor is {div_hi, div_lo} (high byte in bits 15:8). A bit period whose stretch bit is 0 lasts exactly that many clock cycles.
- R2: Bit n of a character, counted from 0 at the first period after a start pulse, uses stretch bit mod_pat[n mod 8]. When that bit is 1, the period lasts divisor+1 cycles. The pattern repeats every 8 bit periods.
- R3: Any 8 consecutive bit periods beginning at a start pulse last exactly 8*divisor + popcount(mod_pat) cycles in total. The average period is therefore divisor + popcount/8.
- R4: A divisor below 3 (values 0, 1, 2) is treated as 3.
- R5: bit_edge is high for exactly one cycle per bit period, on the last cycle of that period.
- R6: mid_sample is high for exactly one cycle per bit period, in cycle floor(L/2) of the period. The period's first cycle is cycle 0 and L is the period length. It never coincides with bit_edge.
- R7: start resets the period counter and the bit index. The cycle after the edge that samples start is cycle 0 of bit 0, whatever the timing was doing before.
- R8: os_en is high every clock when the divisor is 0x001F or less. Otherwise it is high once every 2^s clocks, where s is the bit position of the divisor's most significant 1 minus 4. s is 1 for 0x0020..0x003F and rises by one for each doubling, up to s = 11 for 0x8000..0xFFFF.
- R9: For divisors of 16 and above, the number of os_en pulses in a bit period with no stretch is floor(divisor / 2^s). This number lies between 16 and 31.
- R10: While rst is high, bit_edge and mid_sample are low and os_en is high. The decoded range resets to the undivided setting.
- R11: start also realigns the oversampling divider. Counting cycles from 0 after start, os_en is high in cycle k exactly when k mod 2^s equals 2^s - 1.
- R12: The divisor and pattern inputs pass through one register stage. New settings take effect for a start pulse raised at least two cycles after they change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Realigns bit timing and oversampling divider |
| div_hi | input | 8 | Divisor high byte |
| div_lo | input | 8 | Divisor low byte |
| mod_pat | input | 8 | Per-bit stretch pattern, bit n for bit period n |
| bit_edge | output | 1 | Last cycle of a bit period |
| mid_sample | output | 1 | Mid-bit receive sample point |
| os_en | output | 1 | Oversampling clock enable |

## Verification
The assertions take for granted that the divisor and stretch pattern hold steady for a whole character. They also assume that a start pulse follows any change by at least two cycles, so that the registered range decode has settled. The stimulus writes new settings only between characters. It waits two idle cycles and only then raises a single-cycle start. It also restarts while the previous timing is still running, which exercises realignment. The oversampling checks step across both ends of every divisor range, from the undivided setting to the divide-by-2048 setting.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int BYTE_W    = 8;
  localparam int STRETCH_W = 8;
  localparam int MIN_DIV   = 3;
  localparam int OS_LOG    = 4;

  typedef struct packed {
    logic edge_s;
    logic mid_s;
    logic os_s;
  } baud_strobe_t;

endpackage

// File: rtl/baud_range_sel.sv
module baud_range_sel #(
  parameter int DIV_W   = 16,
  parameter int DIV_MIN = 3,
  parameter int OS_LOG  = 4,
  parameter int SH_W    = 4,
  parameter bit REG_CFG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_raw,
  output logic [DIV_W-1:0] div_eff,
  output logic [SH_W-1:0]  os_shift
);

  localparam int MSB_W = $clog2(DIV_W);

  logic [MSB_W-1:0] top_bit;
  logic [DIV_W-1:0] clamp_c;
  logic [SH_W-1:0]  sh_c;

  always_comb begin
    top_bit = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (div_raw[i]) top_bit = MSB_W'(i);
    end
    if (top_bit > MSB_W'(OS_LOG)) sh_c = SH_W'(top_bit - MSB_W'(OS_LOG));
    else                          sh_c = '0;
    if (div_raw < DIV_W'(DIV_MIN)) clamp_c = DIV_W'(DIV_MIN);
    else                           clamp_c = div_raw;
  end

  generate
    if (REG_CFG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          div_eff  <= DIV_W'(DIV_MIN);
          os_shift <= '0;
        end else begin
          div_eff  <= clamp_c;
          os_shift <= sh_c;
        end
      end
    end else begin : g_comb
      assign div_eff  = clamp_c;
      assign os_shift = sh_c;
    end
  endgenerate

  AST_CLAMP_FLOOR: assert property (@(posedge clk) disable iff (rst)
    div_eff >= DIV_W'(DIV_MIN)); // R4

  AST_OS_RATIO: assert property (@(posedge clk) disable iff (rst)
    ((div_eff >> os_shift) <= DIV_W'(31)) &&
    ((os_shift == '0) || ((div_eff >> os_shift) >= DIV_W'(16)))); // R9

endmodule

// File: rtl/baud_bit_timer.sv
module baud_bit_timer #(
  parameter int DIV_W = 16,
  parameter int MOD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIV_W-1:0] div_eff,
  input  logic [MOD_W-1:0] mod_pat,
  output logic             bit_edge,
  output logic             mid_pulse
);

  localparam int IDX_W = $clog2(MOD_W);
  localparam int LEN_W = DIV_W + 1;

  logic [LEN_W-1:0] cnt_q, cnt_d, cur_len, nxt_len;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             at_end, edge_d, mid_d;

  function automatic logic [LEN_W-1:0] period_of(input logic [DIV_W-1:0] d,
                                                  input logic stretch);
    return {1'b0, d} + {{DIV_W{1'b0}}, stretch};
  endfunction

  always_comb begin
    cur_len = period_of(div_eff, mod_pat[idx_q]);
    at_end  = (cnt_q >= cur_len - LEN_W'(1));
    if (start) begin
      cnt_d = '0;
      idx_d = '0;
    end else if (at_end) begin
      cnt_d = '0;
      idx_d = idx_q + IDX_W'(1);
    end else begin
      cnt_d = cnt_q + LEN_W'(1);
      idx_d = idx_q;
    end
    nxt_len = period_of(div_eff, mod_pat[idx_d]);
    edge_d  = (cnt_d >= nxt_len - LEN_W'(1));
    mid_d   = (cnt_d == (nxt_len >> 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      idx_q     <= '0;
      bit_edge  <= 1'b0;
      mid_pulse <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      idx_q     <= idx_d;
      bit_edge  <= edge_d;
      mid_pulse <= mid_d;
    end
  end

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bit_edge |=> !bit_edge); // R5

  AST_MID_APART: assert property (@(posedge clk) disable iff (rst)
    !(bit_edge && mid_pulse)); // R6

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst || start)
    bit_edge |=> (idx_q == IDX_W'($past(idx_q) + IDX_W'(1)))); // R2

  AST_START_ALIGN: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt_q == '0 && idx_q == '0)); // R7

endmodule

// File: rtl/baud_os_tick.sv
module baud_os_tick #(
  parameter int MAX_SH = 11,
  parameter int SH_W   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [SH_W-1:0] os_shift,
  output logic            os_en
);

  logic [MAX_SH-1:0] pc_q, pc_d, mask;
  logic              os_d;

  always_comb begin
    mask = MAX_SH'((32'd1 << os_shift) - 32'd1);
    pc_d = start ? '0 : pc_q + MAX_SH'(1);
    os_d = ((pc_d & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      os_en <= (mask == '0);
    end else begin
      pc_q  <= pc_d;
      os_en <= os_d;
    end
  end

  AST_OS_FULLRATE: assert property (@(posedge clk) disable iff (rst)
    ($past(os_shift) == '0) |-> os_en); // R8

  AST_OS_START_GAP: assert property (@(posedge clk) disable iff (rst)
    (start && os_shift != '0) |=> !os_en); // R11

endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
  import baud_pkg::*;
#(
  parameter int BYTE_W  = baud_pkg::BYTE_W,
  parameter int MOD_W   = baud_pkg::STRETCH_W,
  parameter int DIV_MIN = baud_pkg::MIN_DIV,
  parameter int OS_LOW  = baud_pkg::OS_LOG,
  parameter bit REG_CFG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] div_hi,
  input  logic [BYTE_W-1:0] div_lo,
  input  logic [MOD_W-1:0]  mod_pat,
  output logic              bit_edge,
  output logic              mid_sample,
  output logic              os_en
);

  localparam int DIV_W  = 2 * BYTE_W;
  localparam int MAX_SH = DIV_W - 1 - OS_LOW;
  localparam int SH_W   = $clog2(MAX_SH + 1);

  logic [DIV_W-1:0] div_raw, div_eff;
  logic [SH_W-1:0]  os_shift;
  logic [MOD_W-1:0] mod_q;
  baud_strobe_t     strb;

  assign div_raw = {div_hi, div_lo};

  generate
    if (REG_CFG) begin : g_mod_reg
      always_ff @(posedge clk) begin
        if (rst) mod_q <= '0;
        else     mod_q <= mod_pat;
      end
    end else begin : g_mod_comb
      assign mod_q = mod_pat;
    end
  endgenerate

  baud_range_sel #(
    .DIV_W  (DIV_W),
    .DIV_MIN(DIV_MIN),
    .OS_LOG (OS_LOW),
    .SH_W   (SH_W),
    .REG_CFG(REG_CFG)
  ) u_range (
    .clk     (clk),
    .rst     (rst),
    .div_raw (div_raw),
    .div_eff (div_eff),
    .os_shift(os_shift)
  );

  baud_bit_timer #(
    .DIV_W(DIV_W),
    .MOD_W(MOD_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .div_eff  (div_eff),
    .mod_pat  (mod_q),
    .bit_edge (strb.edge_s),
    .mid_pulse(strb.mid_s)
  );

  baud_os_tick #(
    .MAX_SH(MAX_SH),
    .SH_W  (SH_W)
  ) u_os (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .os_shift(os_shift),
    .os_en   (strb.os_s)
  );

  assign bit_edge   = strb.edge_s;
  assign mid_sample = strb.mid_s;
  assign os_en      = strb.os_s;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    mid_sample |-> !bit_edge); // R6

endmodule

// File: tb/baud_frac_gen_bench.sv
`timescale 1ns/1ps
module baud_frac_gen_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] div_hi = 8'd0;
  logic [7:0] div_lo = 8'd9;
  logic [7:0] mod_pat = 8'd0;
  logic       bit_edge, mid_sample, os_en;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  int n_edges = 0;
  int edge8 = -1;
  bit armed = 1'b0;

  typedef struct {
    int    cyc;
    string tag;
  } exp_t;

  exp_t q_edge[$];
  exp_t q_mid[$];

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  baud_frac_gen u_baud_frac_gen (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .div_hi    (div_hi),
    .div_lo    (div_lo),
    .mod_pat   (mod_pat),
    .bit_edge  (bit_edge),
    .mid_sample(mid_sample),
    .os_en     (os_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: pops expected strobe cycles as strobes appear
  always @(negedge clk) begin
    #1;
    if (armed) begin
      if (bit_edge) begin
        n_edges++;
        if (n_edges == 8) edge8 = cyc;
        if (q_edge.size() == 0) chk("R5 extra bit_edge", cyc, -1);
        else begin
          exp_t it;
          it = q_edge.pop_front();
          chk(it.tag, cyc, it.cyc);
        end
      end
      if (mid_sample) begin
        if (q_mid.size() == 0) chk("R6 extra mid_sample", cyc, -1);
        else begin
          exp_t it;
          it = q_mid.pop_front();
          chk(it.tag, cyc, it.cyc);
        end
      end
    end
  end

  function automatic int shift_of(input int v);
    int s = 0;
    while (s < 11 && (v >> (s + 5)) != 0) s++;
    return s;
  endfunction

  task automatic load_and_start(input int v, input logic [7:0] mp);
    @(negedge clk);
    div_hi  = 8'(v >> 8);
    div_lo  = 8'(v & 255);
    mod_pat = mp;
    repeat (2) @(negedge clk);   // R12: settings settle before start
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // driver: pushes expected strobe cycles for nbits bit periods
  task automatic run_case(input int v, input logic [7:0] mp, input int nbits);
    int dc, c0, acc, len, pop;
    armed = 1'b0;
    q_edge.delete();
    q_mid.delete();
    load_and_start(v, mp);
    c0 = cyc;
    n_edges = 0;
    edge8 = -1;
    dc = (v < 3) ? 3 : v;        // R4
    pop = $countones(mp);
    acc = 0;
    for (int b = 0; b < nbits; b++) begin
      exp_t e, m;
      len = dc + int'(mp[b % 8]);
      m.cyc = c0 + acc + len / 2;
      m.tag = "R6 mid point";
      e.cyc = c0 + acc + len - 1;
      if (b == 0)            e.tag = "R7 first edge after start";
      else if (mp[b % 8])    e.tag = "R2 stretched period";
      else                   e.tag = "R1 plain period";
      q_mid.push_back(m);
      q_edge.push_back(e);
      acc += len;
    end
    armed = 1'b1;
    while (q_edge.size() != 0 || q_mid.size() != 0) @(negedge clk);
    chk("R3 eight-bit span", edge8 - c0 + 1, 8 * dc + pop);
  endtask

  task automatic run_os(input int v);
    int s, per, dc, win, pulses, first_k, bad_k, bad_v;
    armed = 1'b0;
    load_and_start(v, 8'h00);
    s = shift_of(v);
    per = 1 << s;
    dc = (v < 3) ? 3 : v;
    win = 2 * per + 4;
    if (v < 4096 && dc > win) win = dc;
    pulses = 0;
    first_k = -1;
    bad_k = -1;
    bad_v = 0;
    for (int k = 0; k < win; k++) begin
      if (k > 0) @(negedge clk);
      #1;
      if (os_en && first_k < 0) first_k = k;
      if ((os_en == 1'b1) != ((k % per) == per - 1) && bad_k < 0) begin
        bad_k = k;
        bad_v = int'(os_en);
      end
      if (k < dc && os_en) pulses++;
    end
    chk("R11 first os_en after start", first_k, per - 1);
    chk("R8 os_en cadence, first wrong cycle", bad_k, -1);
    if (bad_k >= 0) $display("  (divisor %0h: os_en=%0d at offset %0d)", v, bad_v, bad_k);
    if (v >= 16 && v < 4096) begin
      chk("R9 os pulses per bit", pulses, dc / per);
      chk("R9 os ratio in 16..31", int'(pulses >= 16 && pulses <= 31), 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 bit_edge in reset", int'(bit_edge), 0);
    chk("R10 mid_sample in reset", int'(mid_sample), 0);
    chk("R10 os_en in reset", int'(os_en), 1);
    @(negedge clk);
    rst = 1'b0;

    run_case(9, 8'h00, 16);        // R1
    run_case(3, 8'h4A, 16);        // R2
    run_case(9, 8'h08, 16);        // R2
    run_case(0, 8'hFF, 16);        // R4
    run_case(2, 8'h01, 16);        // R4
    run_case(16'h0123, 8'h55, 16); // R1 high byte used
    run_case(16, 8'h80, 16);       // R2 wrap at bit 7

    begin
      int vals[24] = '{16'h0003, 16'h001F, 16'h0020, 16'h003F, 16'h0040, 16'h007F,
                       16'h0080, 16'h00FF, 16'h0100, 16'h01FF, 16'h0200, 16'h03FF,
                       16'h0400, 16'h07FF, 16'h0800, 16'h0FFF, 16'h1000, 16'h1FFF,
                       16'h2000, 16'h3FFF, 16'h4000, 16'h7FFF, 16'h8000, 16'hFFFF};
      for (int i = 0; i < 24; i++) run_os(vals[i]);  // R8 range edges
    end

    summary();
    $finish;
  end

endmodule